// File: doc/BRIEF.md
# Five-Level Multicarrier PWM Gate Generator

This block drives the five gate signals of a single-phase five-level inverter. The inverter is an H-bridge of four switches plus one auxiliary switch. A digital sine reference is compared against four stacked triangular carriers of equal amplitude. The number of carriers that the reference lies strictly above gives one of five output levels. Each level is then mapped to a pair of conducting switches.

Two inputs select how the carriers are phased relative to one another: all in phase, the upper pair opposite the lower pair, or each band opposite its neighbour. An 8-bit modulation index scales the sine amplitude. A new carrier arrangement is adopted only when the carriers return to their common minimum, so a gate output never glitches on a mode change.

The triangle generator is a two-state machine. The states are `SWEEP_RISE` and `SWEEP_FALL`. The machine moves from `SWEEP_RISE` to `SWEEP_FALL` on the tick that brings the ramp to its peak. It moves from `SWEEP_FALL` back to `SWEEP_RISE` on the tick that brings the ramp to zero. That second transition is the carrier period boundary.

Top module: `ml5_carrier_pwm`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `gate_o` is 5'b00011. After reset the ramp is at 0, the sweep is rising, the sine index is 0 and the carrier arrangement is code 00.
- R2: The shared ramp R steps by one on every carrier tick, from 0 up to C = 2^CW and back down to 0. One carrier period is 2·C ticks. A tick occurs once every `TICK_DIV` clocks.
- R3: The sine index p (0..63) advances by one at each period boundary. The reference is floor(S(p)·M·2C / 16384), where S(p) = round(127·sin(2πp/64)) and M is the effective modulation index.
- R4: Band k (k = 0..3, with band 0 the lowest) has carrier value (k−2)·C + r_k. The output level is n − 2, where n is the number of bands whose carrier value the reference is strictly greater than.
- R5: With code 00 (in phase), every band uses r_k = R.
- R6: With code 01 (opposition), bands 2 and 3 use R and bands 0 and 1 use C − R.
- R7: With code 10 (alternating opposition), bands 0 and 2 use R and bands 1 and 3 use C − R.
- R8: Code 11 on `tech_sel` is ignored. The arrangement in force stays unchanged.
- R9: `tech_sel` is sampled only at a period boundary, which is the tick on which R returns to 0. The new arrangement governs the gates from the following clock onward.
- R10: Bit i−1 of `gate_o` drives switch i. The level-to-switch mapping is:
  - +2 gives S1+S4 (01001).
  - +1 gives S4+S5 (11000).
  - 0 gives S1+S2 (00011) when p < 32, and S3+S4 (01100) when p ≥ 32.
  - −1 gives S3+S5 (10100).
  - −2 gives S2+S3 (00110).
  `gate_o` is registered, so it reflects the state of the previous clock.
- R11: Exactly two gates are on at every cycle. S1 and S3 are never on together, and S2 and S4 are never on together.
- R12: A `mod_index` value M is read as M/128. Values above 128 are treated as 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tech_sel | input | 2 | Carrier arrangement: 00 in phase, 01 opposition, 10 alternating opposition, 11 ignored |
| mod_index | input | 8 | Modulation index in units of 1/128 (127 ≈ 0.99, 115 ≈ 0.9, 90 ≈ 0.7, 64 = 0.5) |
| gate_o | output | 5 | Registered gate drives for S1..S5 (bit 0 = S1) |

## Verification
A wrong sweep state or ramp value changes the level count within a tick, so `gate_o` diverges from the expected switch pair on the very next clock. A wrongly latched arrangement code shows up as mismatched pairs during the carrier period that follows the boundary. A sine index that slips or advances at the wrong moment shows up as level errors at the next boundary. A wrong half-cycle flag shows up in the zero-level pair that is chosen. The bench compares every clock of complete fundamental cycles against an arithmetic model, in every arrangement and at several index values, so any of these faults is caught within one carrier period of its cause.

// File: rtl/ml5_pwm_pkg.sv
package ml5_pwm_pkg;

    typedef enum logic [1:0] {
        TECH_PD   = 2'b00,
        TECH_POD  = 2'b01,
        TECH_APOD = 2'b10
    } tech_e;

    typedef enum logic {
        SWEEP_RISE = 1'b0,
        SWEEP_FALL = 1'b1
    } sweep_e;

    localparam logic [1:0] TECH_RESERVED = 2'b11;
    localparam int         SINE_IDX_W    = 6;
    localparam int         MI_W          = 8;
    localparam int         MI_UNITY      = 128;
    localparam int         GATE_N        = 5;
    localparam logic [GATE_N-1:0] GATE_ZERO_POS = 5'b00011;
    localparam logic [GATE_N-1:0] GATE_ZERO_NEG = 5'b01100;
    localparam logic [GATE_N-1:0] GATE_POS2     = 5'b01001;
    localparam logic [GATE_N-1:0] GATE_POS1     = 5'b11000;
    localparam logic [GATE_N-1:0] GATE_NEG1     = 5'b10100;
    localparam logic [GATE_N-1:0] GATE_NEG2     = 5'b00110;

endpackage

// File: rtl/ml5_ramp_sweep.sv
module ml5_ramp_sweep
    import ml5_pwm_pkg::*;
#(
    parameter int CW       = 6,
    parameter int TICK_DIV = 195
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [CW:0] ramp_o,
    output logic        period_end_o
);
    localparam int          PW   = $clog2(TICK_DIV + 1);
    localparam logic [CW:0] PEAK = (CW+1)'(2**CW);

    logic [PW-1:0] pre_q;
    logic          tick;
    sweep_e        st_q, st_d;
    logic [CW:0]   ramp_q, ramp_d;

    assign tick = (pre_q == PW'(TICK_DIV - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SWEEP_RISE;
            ramp_q <= '0;
        end else begin
            st_q   <= st_d;
            ramp_q <= ramp_d;
        end
    end

    // next state and ramp
    always_comb begin
        st_d   = st_q;
        ramp_d = ramp_q;
        if (tick) begin
            unique case (st_q)
                SWEEP_RISE: begin
                    ramp_d = ramp_q + 1'b1;
                    if (ramp_q == PEAK - 1'b1) st_d = SWEEP_FALL;
                end
                SWEEP_FALL: begin
                    ramp_d = ramp_q - 1'b1;
                    if (ramp_q == 1) st_d = SWEEP_RISE;
                end
            endcase
        end
    end

    assign ramp_o       = ramp_q;
    assign period_end_o = tick && (st_q == SWEEP_FALL) && (ramp_q == 1);

endmodule

// File: rtl/ml5_sine_ref.sv
module ml5_sine_ref
    import ml5_pwm_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   advance_i,
    input  logic [MI_W-1:0]        mi_i,
    output logic signed [CW+2:0]   ref_o,
    output logic                   neg_half_o
);
    localparam int RW = CW + 3;

    logic [SINE_IDX_W-1:0] idx_q;
    logic [4:0]            jq;
    logic [6:0]            mag;
    logic signed [8:0]     s9;
    logic [MI_W-1:0]       mic;
    logic signed [31:0]    prod;

    // quarter-wave magnitude, round(127*sin(j*pi/32)), j = 0..16
    function automatic logic [6:0] qsin(input logic [4:0] j);
        case (j)
            5'd0:  qsin = 7'd0;
            5'd1:  qsin = 7'd12;
            5'd2:  qsin = 7'd25;
            5'd3:  qsin = 7'd37;
            5'd4:  qsin = 7'd49;
            5'd5:  qsin = 7'd60;
            5'd6:  qsin = 7'd71;
            5'd7:  qsin = 7'd81;
            5'd8:  qsin = 7'd90;
            5'd9:  qsin = 7'd98;
            5'd10: qsin = 7'd106;
            5'd11: qsin = 7'd112;
            5'd12: qsin = 7'd117;
            5'd13: qsin = 7'd122;
            5'd14: qsin = 7'd125;
            5'd15: qsin = 7'd126;
            5'd16: qsin = 7'd127;
            default: qsin = 7'd0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n)         idx_q <= '0;
        else if (advance_i) idx_q <= idx_q + 1'b1;
    end

    assign jq   = idx_q[4] ? (5'd16 - {1'b0, idx_q[3:0]}) : {1'b0, idx_q[3:0]};
    assign mag  = qsin(jq);
    assign s9   = idx_q[5] ? -$signed({2'b00, mag}) : $signed({2'b00, mag});
    assign mic  = (mi_i > MI_W'(MI_UNITY)) ? MI_W'(MI_UNITY) : mi_i;
    assign prod = (32'(s9) * $signed({24'b0, mic})) <<< (CW + 1);

    assign ref_o      = RW'(prod >>> 14);
    assign neg_half_o = idx_q[5];

endmodule

// File: rtl/ml5_level_map.sv
module ml5_level_map
    import ml5_pwm_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic [CW:0]          ramp_i,
    input  tech_e                tech_i,
    input  logic signed [CW+2:0] ref_i,
    input  logic                 neg_half_i,
    output logic [GATE_N-1:0]    gate_d_o
);
    localparam int          RW    = CW + 3;
    localparam int          NBAND = 4;
    localparam logic [CW:0] PEAK  = (CW+1)'(2**CW);

    logic [NBAND-1:0] inv;
    logic [NBAND-1:0] above;
    logic [2:0]       n_above;

    always_comb begin
        case (tech_i)
            TECH_POD:  inv = 4'b0011;
            TECH_APOD: inv = 4'b1010;
            default:   inv = 4'b0000;
        endcase
    end

    for (genvar k = 0; k < NBAND; k++) begin : g_band
        localparam int OFS = (k - 2) * (2**CW);
        logic [CW:0]          r_eff;
        logic signed [RW-1:0] car;
        assign r_eff    = inv[k] ? (PEAK - ramp_i) : ramp_i;
        assign car      = RW'(OFS) + $signed({2'b00, r_eff});
        assign above[k] = (ref_i > car);
    end

    always_comb begin
        n_above = '0;
        for (int k = 0; k < NBAND; k++) n_above = n_above + 3'(above[k]);
    end

    always_comb begin
        case (n_above)
            3'd4:    gate_d_o = GATE_POS2;
            3'd3:    gate_d_o = GATE_POS1;
            3'd2:    gate_d_o = neg_half_i ? GATE_ZERO_NEG : GATE_ZERO_POS;
            3'd1:    gate_d_o = GATE_NEG1;
            default: gate_d_o = GATE_NEG2;
        endcase
    end

endmodule

// File: rtl/ml5_carrier_pwm.sv
module ml5_carrier_pwm
    import ml5_pwm_pkg::*;
#(
    parameter int CW       = 6,
    parameter int TICK_DIV = 195
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  tech_sel,
    input  logic [7:0]  mod_index,
    output logic [4:0]  gate_o
);
    logic [CW:0]          ramp_cnt;
    logic                 period_end;
    logic signed [CW+2:0] ref_val;
    logic                 neg_half;
    tech_e                tech_q;
    logic [GATE_N-1:0]    gate_d;

    ml5_ramp_sweep #(.CW(CW), .TICK_DIV(TICK_DIV)) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .ramp_o       (ramp_cnt),
        .period_end_o (period_end)
    );

    ml5_sine_ref #(.CW(CW)) u_sine (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance_i  (period_end),
        .mi_i       (mod_index),
        .ref_o      (ref_val),
        .neg_half_o (neg_half)
    );

    ml5_level_map #(.CW(CW)) u_map (
        .ramp_i     (ramp_cnt),
        .tech_i     (tech_q),
        .ref_i      (ref_val),
        .neg_half_i (neg_half),
        .gate_d_o   (gate_d)
    );

    // arrangement register: loaded only at a carrier period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            tech_q <= TECH_PD;
        else if (period_end && (tech_sel != TECH_RESERVED))
            tech_q <= tech_e'(tech_sel);
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) gate_o <= GATE_ZERO_POS;
        else        gate_o <= gate_d;
    end

endmodule

// File: rtl/ml5_pwm_checker.sv
module ml5_pwm_checker #(
    parameter int CW = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  tech_sel,
    input logic [4:0]  gate,
    input logic [CW:0] ramp,
    input logic [1:0]  tech,
    input logic        period_end
);
    localparam logic [CW:0] PEAK = (CW+1)'(2**CW);

    assert_two_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gate) == 2);

    assert_no_leg_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate[0] && gate[2]) && !(gate[1] && gate[3]));

    assert_ramp_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ramp <= PEAK);

    assert_ramp_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ramp) |-> ((ramp == $past(ramp) + 1'b1) || (ramp + 1'b1 == $past(ramp))));

    assert_tech_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tech) |-> $past(period_end));

    assert_reserved_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && tech_sel == 2'b11) |=> $stable(tech));

endmodule

bind ml5_carrier_pwm ml5_pwm_checker #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tech_sel   (tech_sel),
    .gate       (gate_o),
    .ramp       (ramp_cnt),
    .tech       (tech_q),
    .period_end (period_end)
);

// File: tb/tb_ml5_carrier_pwm.sv
`timescale 1ns/1ps
module tb_ml5_carrier_pwm;
    localparam int CW = 4;
    localparam int C  = 2**CW;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] tech_sel = 2'b00;
    logic [7:0] mod_index = 8'd127;
    logic [4:0] gate_o;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    chk_en = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // bench model state
    int         m_ramp, m_idx, m_tech;
    bit         m_rise;
    logic [4:0] exp_q;

    always #10 clk = ~clk;

    ml5_carrier_pwm #(.CW(CW), .TICK_DIV(1)) dut (
        .clk(clk), .rst_n(rst_n), .tech_sel(tech_sel),
        .mod_index(mod_index), .gate_o(gate_o));

    function automatic int sine_q7(int p);
        real a;
        a = 127.0 * $sin(2.0 * 3.14159265358979 * p / 64.0);
        if (a >= 0.0) return $rtoi(a + 0.5);
        return -$rtoi(-a + 0.5);
    endfunction

    function automatic logic [4:0] expect_gate(int rmp, int tech, int idx, int mi);
        int mic, v, rf, n;
        mic = (mi > 128) ? 128 : mi;
        v   = sine_q7(idx) * mic * 2 * C;
        rf  = (v >= 0) ? v / 16384 : -((-v + 16383) / 16384);
        n   = 0;
        for (int k = 0; k < 4; k++) begin
            bit inv;
            int r;
            inv = (tech == 1 && k < 2) || (tech == 2 && (k % 2) == 1);
            r   = inv ? (C - rmp) : rmp;
            if (rf > (k - 2) * C + r) n++;
        end
        case (n)
            4: return 5'b01001;
            3: return 5'b11000;
            2: return (idx >= 32) ? 5'b01100 : 5'b00011;
            1: return 5'b10100;
            default: return 5'b00110;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ramp <= 0; m_rise <= 1'b1; m_idx <= 0; m_tech <= 0;
            exp_q  <= 5'b00011;
        end else begin
            exp_q <= expect_gate(m_ramp, m_tech, m_idx, int'(mod_index));
            if (m_rise) begin
                m_ramp <= m_ramp + 1;
                if (m_ramp + 1 == C) m_rise <= 1'b0;
            end else begin
                m_ramp <= m_ramp - 1;
                if (m_ramp == 1) begin
                    m_rise <= 1'b1;
                    m_idx  <= (m_idx + 1) % 64;
                    if (tech_sel != 2'b11) m_tech <= int'(tech_sel);
                end
            end
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            n_chk++;
            if (gate_o !== exp_q) begin
                n_fail++;
                $display("FAIL %s R10 gate actual=%b expected=%b", tag, gate_o, exp_q);
            end
            n_chk++;
            if ($countones(gate_o) != 2 || (gate_o[0] && gate_o[2]) || (gate_o[1] && gate_o[3])) begin
                n_fail++;
                $display("FAIL R11 pair actual=%b expected=two-on-no-leg-short", gate_o);
            end
        end
    end

    task automatic run_phase(string t, logic [1:0] sel, logic [7:0] mi, int cycles);
        @(negedge clk);
        tag = t; tech_sel = sel; mod_index = mi;
        repeat (cycles) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset value
        n_chk++;
        if (gate_o !== 5'b00011) begin
            n_fail++;
            $display("FAIL R1 reset actual=%b expected=00011", gate_o);
        end
        rst_n = 1'b1;
        chk_en = 1'b1;
        run_phase("R2 R5", 2'b00, 8'd127, 2048);
        run_phase("R6",    2'b01, 8'd115, 2048);
        run_phase("R7",    2'b10, 8'd90,  2048);
        run_phase("R8",    2'b11, 8'd90,  2048);
        run_phase("R3",    2'b00, 8'd64,  2048);
        run_phase("R4",    2'b01, 8'd0,   1024);
        run_phase("R4",    2'b10, 8'd128, 2048);
        run_phase("R12",   2'b01, 8'd255, 2048);
        for (int i = 0; i < 60; i++) begin
            logic [1:0] s;
            s = 2'(i % 4);
            run_phase("R9", s, 8'd110, 37);
        end
        chk_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule